// File: doc/BRIEF.md
# Prioritized Interrupt Selector with Delegation

This block looks at the interrupt request state of a hart once per cycle and decides whether an interrupt trap must be taken, and with which cause. It takes a pending vector, an enable vector, a delegation mask, the current privilege level and the two global enable bits, one for machine level and one for supervisor level. It raises a take-trap flag and reports a cause word whose top bit marks the trap as an interrupt. The trap entry sequence itself lives elsewhere: saving state, picking the vector address and changing privilege.

A request counts only when its pending bit and its enable bit are both set. A request with its delegation bit clear belongs to machine level. A request with its delegation bit set belongs to supervisor level. Each group passes only while its own level accepts interrupts. Among the requests that pass, the lowest index wins. The decision is combinational. With `REG_OUT = 1` (the default) it goes through one register stage, so the outputs follow the inputs one clock later. With `REG_OUT = 0` the outputs are combinational.

These are control pins sampled every cycle. There is no stream and no handshake.

Top module: `irq_pick`

## Requirements
- R1: A request bit `i` can be selected only if both `irq_pend[i]` and `irq_en[i]` are 1. A bit that is set in one vector but not the other is never reported.
- R2: Machine level accepts interrupts when `cur_priv` is below 3 (machine), whatever `m_gie` is. At `cur_priv` = 3 it accepts them only while `m_gie` = 1.
- R3: A request with `irq_deleg[i]` = 0 is taken only while machine level accepts interrupts (R2).
- R4: A request with `irq_deleg[i]` = 1 is taken only while supervisor level accepts interrupts. That is the case when `cur_priv` = 0 (user), or when `cur_priv` = 1 (supervisor) and `s_gie` = 1. It is never the case at `cur_priv` = 3.
- R5: When several requests pass their gating, the one with the lowest index is reported.
- R6: On a taken interrupt, `trap_cause` has bit XLEN-1 set and the winning index in its low bits. Every other bit is 0. For example, index 3 with XLEN = 32 gives 0x80000003.
- R7: When no request passes, `take_trap` is 0 and `trap_cause` is 0.
- R8: With `REG_OUT = 1`, both outputs show the decision for the inputs present at the previous rising clock edge. While `rst_n` is low, both outputs are 0.
- R9: The privilege encoding is 0 = user, 1 = supervisor, 3 = machine. The unused code 2 is treated as a level below machine that is not user or supervisor. Undelegated requests pass there, and delegated requests do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| irq_pend | input | NUM_IRQ (16) | Pending request bits |
| irq_en | input | NUM_IRQ (16) | Per-request enable bits |
| irq_deleg | input | NUM_IRQ (16) | 1 = request handled at supervisor level |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take_trap | output | 1 | An interrupt trap must be taken |
| trap_cause | output | XLEN (32) | Interrupt flag in the top bit, winning index in the low bits |

## Verification
Single requests are placed at the two ends of the vector to test the index encoding and the interrupt flag. Pairs of requests at different indices show whether the lowest index wins. A delegated request is set next to an undelegated one and the privilege level and global enables are swept through every combination. This separates the machine gating condition from the supervisor gating condition, including the unused privilege code. Mismatched pending and enable bits, together with a long run of random vectors checked against a behavioural model on every cycle, catch masking errors and off-by-one latency in the output stage.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               m_open,
  output logic               s_open,
  output logic [NUM_IRQ-1:0] live
);
  logic [NUM_IRQ-1:0] armed;

  // machine level: anything below machine, or machine with its global enable
  assign m_open = (priv != PRIV_MACH) || m_gie;
  // supervisor level: user, or supervisor with its global enable
  assign s_open = (priv == PRIV_USER) || ((priv == PRIV_SUPV) && s_gie);

  assign armed = pend & en;
  assign live  = (armed & ~deleg & {NUM_IRQ{m_open}})
               | (armed &  deleg & {NUM_IRQ{s_open}});
endmodule

// File: rtl/irq_lsb_find.sv
module irq_lsb_find #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_IRQ:0]   seen;
  logic [NUM_IRQ-1:0] first;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_IRQ; g++) begin : g_chain
      assign first[g]  = vec[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec[g];
    end
  endgenerate

  // first is one-hot or zero: OR together the index of the single hit
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

  assign found = seen[NUM_IRQ];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pick_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IRQ-1:0]  irq_pend,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic [NUM_IRQ-1:0]  irq_deleg,
  input  logic [1:0]          cur_priv,
  input  logic                m_gie,
  input  logic                s_gie,
  output logic                take_trap,
  output logic [XLEN-1:0]     trap_cause
);
  logic [NUM_IRQ-1:0] live;
  logic               m_open;
  logic               s_open;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic [XLEN-1:0]    cause_d;

  irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend   (irq_pend),
    .en     (irq_en),
    .deleg  (irq_deleg),
    .priv   (cur_priv),
    .m_gie  (m_gie),
    .s_gie  (s_gie),
    .m_open (m_open),
    .s_open (s_open),
    .live   (live)
  );

  irq_lsb_find #(.NUM_IRQ(NUM_IRQ)) u_find (
    .vec   (live),
    .found (found),
    .idx   (idx)
  );

  always_comb begin
    cause_d = '0;
    if (found) begin
      cause_d[XLEN-1]  = 1'b1;
      cause_d[IDX_W-1:0] = idx;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          take_trap  <= 1'b0;
          trap_cause <= '0;
        end else begin
          take_trap  <= found;
          trap_cause <= cause_d;
        end
      end
    end else begin : g_comb
      assign take_trap  = found;
      assign trap_cause = cause_d;
    end
  endgenerate

  // gate output never holds a bit that is not both pending and enabled
  p_armed_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live & ~(irq_pend & irq_en)) == '0);

  // machine privilege with global enable off blocks undelegated bits
  p_mach_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_priv == PRIV_MACH) && !m_gie) |-> ((live & ~irq_deleg) == '0));

  // machine privilege never lets delegated bits through
  p_deleg_in_mach_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == PRIV_MACH) |-> ((live & irq_deleg) == '0));

  // the finder's choice is a live bit with nothing live below it
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (live[idx] && ((live & ((NUM_IRQ'(1) << idx) - NUM_IRQ'(1))) == '0)));

  // a taken trap carries the interrupt flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> trap_cause[XLEN-1]);

  // idle means an all-zero cause
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take_trap |-> (trap_cause == '0));

  generate
    if (REG_OUT) begin : g_lat_chk
      // registered strobe follows the previous cycle's finder result
      p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (take_trap == $past(found)));
    end
  endgenerate
endmodule

// File: tb/sim_irq_pick.sv
`timescale 1ns/1ps
module sim_irq_pick;
  localparam int N  = 16;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_pend = '0;
  logic [N-1:0]  irq_en = '0;
  logic [N-1:0]  irq_deleg = '0;
  logic [1:0]    cur_priv = 2'd3;
  logic          m_gie = 1'b0;
  logic          s_gie = 1'b0;
  logic          take_trap;
  logic [XL-1:0] trap_cause;

  int errors = 0;
  int checks = 0;
  logic          exp_take = 1'b0;
  logic [XL-1:0] exp_cause = '0;

  always #4 clk = ~clk;

  irq_pick #(.NUM_IRQ(N), .XLEN(XL), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_deleg(irq_deleg), .cur_priv(cur_priv), .m_gie(m_gie), .s_gie(s_gie),
    .take_trap(take_trap), .trap_cause(trap_cause)
  );

  // behavioural reference: gating per level, lowest index first
  task automatic model(input logic [N-1:0] p, e, d, input logic [1:0] pr,
                       input logic mg, sg, output logic t, output logic [XL-1:0] c);
    bit m_ok, s_ok;
    int win;
    m_ok = (pr != 2'd3) || mg;
    s_ok = (pr == 2'd0) || (pr == 2'd1 && sg);
    win = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (p[i] && e[i] && ((!d[i] && m_ok) || (d[i] && s_ok))) win = i;
    end
    t = (win >= 0);
    c = (win >= 0) ? ((XL'(1) << (XL - 1)) | XL'(win)) : '0;
  endtask

  task automatic chk(input string tag, input logic et, input logic [XL-1:0] ec);
    checks++;
    if (take_trap !== et || trap_cause !== ec) begin
      errors++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
               tag, take_trap, trap_cause, et, ec);
    end
  endtask

  task automatic run(input logic [N-1:0] p, e, d, input logic [1:0] pr,
                     input logic mg, sg, input string tag);
    @(negedge clk);
    irq_pend = p; irq_en = e; irq_deleg = d; cur_priv = pr; m_gie = mg; s_gie = sg;
    #1;
    chk({tag, " R8 (old value before edge)"}, exp_take, exp_cause);
    model(p, e, d, pr, mg, sg, exp_take, exp_cause);
    @(negedge clk);
    chk(tag, exp_take, exp_cause);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: take=%0b cause=%h expected run to end", take_trap, trap_cause);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    irq_pend = '1; irq_en = '1; cur_priv = 2'd0;
    repeat (3) @(negedge clk);
    chk("R8 reset clears outputs", 1'b0, '0);
    irq_pend = '0; irq_en = '0; cur_priv = 2'd3;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle after reset", 1'b0, '0);

    run(16'h0004, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b0, "R1 pending without enable");
    run(16'h0000, 16'h0004, 16'h0000, 2'd3, 1'b1, 1'b0, "R1 enable without pending");
    run(16'h0028, 16'h0028, 16'h0000, 2'd3, 1'b1, 1'b0, "R5 bits 3,5 pick 3");
    run(16'h0028, 16'h0020, 16'h0000, 2'd3, 1'b1, 1'b0, "R1 masked bit 3 leaves 5");
    run(16'h0080, 16'h0080, 16'h0000, 2'd3, 1'b0, 1'b0, "R2 R3 machine gie off");
    run(16'h0080, 16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, "R2 supervisor ignores m_gie");
    run(16'h0080, 16'h0080, 16'h0000, 2'd0, 1'b0, 1'b0, "R2 user ignores m_gie");
    run(16'h0002, 16'h0002, 16'h0002, 2'd3, 1'b1, 1'b1, "R4 delegated blocked in machine");
    run(16'h0002, 16'h0002, 16'h0002, 2'd1, 1'b1, 1'b0, "R4 supervisor s_gie off");
    run(16'h0002, 16'h0002, 16'h0002, 2'd1, 1'b0, 1'b1, "R4 supervisor s_gie on");
    run(16'h0002, 16'h0002, 16'h0002, 2'd0, 1'b0, 1'b0, "R4 user takes delegated");
    run(16'h0082, 16'h0082, 16'h0002, 2'd3, 1'b1, 1'b1, "R3 R5 delegated low bit masked, 7 wins");
    run(16'h0082, 16'h0082, 16'h0002, 2'd0, 1'b0, 1'b0, "R5 user both open, 1 wins");
    run(16'h0082, 16'h0082, 16'h0002, 2'd2, 1'b0, 1'b1, "R9 code 2 machine open");
    run(16'h0002, 16'h0002, 16'h0002, 2'd2, 1'b1, 1'b1, "R9 code 2 supervisor closed");
    run(16'h8000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, "R6 index 15");
    run(16'hFFFF, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b0, "R6 index 0");
    run(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, "R7 nothing pending");

    for (int k = 0; k < 400; k++) begin
      run(N'($urandom), N'($urandom), N'($urandom), 2'($urandom),
          1'($urandom), 1'($urandom), "R5 R6 random vectors");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule